// File: doc/BRIEF.md
# I2C Target Controller with 10-bit Addressing

This block lets a processor act as a target on a two-wire I2C bus that uses 10-bit device addresses. It watches the open-drain clock and data lines, finds START, repeated START and STOP conditions, and checks the two address bytes of a transfer against the processor's own address. When the address matches, the block acknowledges bytes that the bus controller writes. After a repeated START with a read header, it shifts bytes out to the bus controller.

The processor sees a small register file: a status word, a control word holding a one-shot reject bit, a data port, and the own address split into a low byte and a high pair. Address hits, received bytes, end of transfer and a not-acknowledge from the bus controller each set a status flag. Any set flag raises the `irq` level. The processor clears the flags by reading the status word or the data port. The block never stretches the clock, so software must keep pace with the bus.

Register map (`reg_addr`): 0 status (read only), 1 control (bit 0 = reject-next), 2 data (a read returns the last received byte, a write loads the next byte to send), 3 own address bits 7..0, 4 own address bits 9..8 in data bits 1..0. Status bits: 0 hit, 1 direction (1 = the bus controller reads), 2 receive-full, 3 end-of-transfer, 4 controller-NAK.

Top module: `i2ct_target`

## Requirements
- R1: After reset the status word reads 0, `irq` is 0 and `sda_oe` is 0.
- R2: A header byte `11110` + own address bits 9..8 + write bit 0, followed by a byte equal to own address bits 7..0, gets an ACK on both bytes. It then sets status bit 0, clears status bit 1 and raises `irq`.
- R3: If the header's address pair or the second address byte differs from the own address, that byte gets no ACK, and every byte until the next START gets no ACK and sets no flag.
- R4: A status read clears status bits 0, 3 and 4 and leaves bit 1 unchanged; `irq` falls once no flag remains.
- R5: Once a target has been addressed for writing, a received data byte is ACKed, status bit 2 is set, and the data port returns the byte. A data port read clears bit 2.
- R6: With control bit 0 set, the next data byte gets a NAK, is still stored with status bit 2 set, and control bit 0 then reads 0.
- R7: A STOP or a repeated START while the target is addressed sets status bit 3 and raises `irq`.
- R8: After a write match, a repeated START and a header with read bit 1 gets an ACK and sets status bits 0 and 1. The target then sends the data port's byte MSB first, and a new byte after each controller ACK.
- R9: A NAK from the bus controller after a sent byte makes the target release SDA and set status bit 4.
- R10: A read header without a preceding write match in the same transfer gets no ACK.
- R11: A bus event that sets a status flag wins over a status read in the same cycle, so a later read still sees the flag.
- R12: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt level, high while any flag is set |

## Verification
Two functions can fall in one clock: the bus engine setting a status flag, and a processor status read clearing the same flag. The bench provokes this without guessing the exact cycle. It reads the status word on every clock for the whole address byte and again across a STOP, so one read must coincide with the cycle in which the flag is set. The result is judged as correct only if one of those reads returns the flag as set. If the clear won, the flag would be lost and never seen.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 10;
  localparam int STAT_W = 5;
  localparam int RA_W   = 3;
  localparam int CNT_W  = $clog2(DATA_W) + 1;

  localparam int STAT_SAM  = 0;
  localparam int STAT_RD   = 1;
  localparam int STAT_RDRF = 2;
  localparam int STAT_STOP = 3;
  localparam int STAT_MNAK = 4;

  localparam logic [RA_W-1:0] REG_STAT   = 3'd0;
  localparam logic [RA_W-1:0] REG_CTRL   = 3'd1;
  localparam logic [RA_W-1:0] REG_DATA   = 3'd2;
  localparam logic [RA_W-1:0] REG_SLA_LO = 3'd3;
  localparam logic [RA_W-1:0] REG_SLA_HI = 3'd4;

  localparam logic [4:0] HDR_MARK = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_AWAIT, ST_ACK, ST_SEND, ST_MACK
  } eng_state_e;

  typedef enum logic [1:0] {PH_HDR, PH_LO, PH_DATA} phase_e;

  // header byte carries the fixed mark and the two upper address bits
  function automatic logic hdr_hit(logic [DATA_W-1:0] b, logic [1:0] hi);
    return (b[7:3] == HDR_MARK) && (b[2:1] == hi);
  endfunction

  // shift one sampled bit into a byte, MSB first
  function automatic logic [DATA_W-1:0] shift_in(logic [DATA_W-1:0] b, logic bit_i);
    return {b[DATA_W-2:0], bit_i};
  endfunction
endpackage

// File: rtl/i2ct_bus_sync.sv
`timescale 1ns/1ps
module i2ct_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2ct_engine.sv
`timescale 1ns/1ps
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] sla,
  input  logic              nak_req,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_drv,
  output logic              ev_addr_hit,
  output logic              ev_hit_rd,
  output logic              ev_rx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ev_nak_used,
  output logic              ev_bus_end,
  output logic              ev_master_nak,
  output logic              eng_idle
);
  eng_state_e        state;
  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh, nb;
  logic              sel, wmatch, ack_q, tx_next;
  logic              hit_w, hit_r, hit_lo;

  assign nb     = shift_in(sh, sda_s);
  assign hit_w  = (phase == PH_HDR) && hdr_hit(nb, sla[9:8]) && !nb[0];
  assign hit_r  = (phase == PH_HDR) && hdr_hit(nb, sla[9:8]) && nb[0] && wmatch;
  assign hit_lo = (phase == PH_LO) && (nb == sla[7:0]);
  assign eng_idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  phase <= PH_HDR;  cnt <= '0;  sh <= '0;
      sel <= 1'b0;  wmatch <= 1'b0;  ack_q <= 1'b0;  tx_next <= 1'b0;
      sda_drv <= 1'b0;  rx_byte <= '0;
      ev_addr_hit <= 1'b0;  ev_hit_rd <= 1'b0;  ev_rx_byte <= 1'b0;
      ev_nak_used <= 1'b0;  ev_bus_end <= 1'b0;  ev_master_nak <= 1'b0;
    end else begin
      ev_addr_hit   <= 1'b0;
      ev_rx_byte    <= 1'b0;
      ev_nak_used   <= 1'b0;
      ev_bus_end    <= 1'b0;
      ev_master_nak <= 1'b0;
      if (bus_stop) begin
        ev_bus_end <= sel;
        sel <= 1'b0;  wmatch <= 1'b0;
        state <= ST_IDLE;  sda_drv <= 1'b0;
      end else if (bus_start) begin
        ev_bus_end <= sel;
        sel <= 1'b0;
        state <= ST_RECV;  phase <= PH_HDR;  cnt <= '0;  sda_drv <= 1'b0;
      end else begin
        unique case (state)
          ST_RECV: if (scl_rise) begin
            sh <= nb;
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt <= '0;
              tx_next <= 1'b0;
              if (phase == PH_DATA) begin
                ev_rx_byte  <= 1'b1;
                rx_byte     <= nb;
                ack_q       <= ~nak_req;
                ev_nak_used <= nak_req;
                state       <= ST_AWAIT;
              end else if (hit_w) begin
                ack_q <= 1'b1;  phase <= PH_LO;  state <= ST_AWAIT;
              end else if (hit_r) begin
                ack_q <= 1'b1;  tx_next <= 1'b1;  sel <= 1'b1;
                ev_addr_hit <= 1'b1;  ev_hit_rd <= 1'b1;  state <= ST_AWAIT;
              end else if (hit_lo) begin
                ack_q <= 1'b1;  sel <= 1'b1;  wmatch <= 1'b1;  phase <= PH_DATA;
                ev_addr_hit <= 1'b1;  ev_hit_rd <= 1'b0;  state <= ST_AWAIT;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_AWAIT: if (scl_fall) begin
            sda_drv <= ack_q;
            state   <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            cnt <= '0;
            if (tx_next) begin
              sh      <= tx_data;
              sda_drv <= ~tx_data[DATA_W-1];
              state   <= ST_SEND;
            end else begin
              sda_drv <= 1'b0;
              state   <= ST_RECV;
            end
          end
          ST_SEND: begin
            if (scl_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt == CNT_W'(DATA_W)) begin
                sda_drv <= 1'b0;
                state   <= ST_MACK;
              end else begin
                sh      <= shift_in(sh, 1'b0);
                sda_drv <= ~sh[DATA_W-2];
              end
            end
          end
          ST_MACK: if (scl_rise) begin
            if (sda_s) begin
              ev_master_nak <= 1'b1;
              state <= ST_IDLE;
            end else begin
              tx_next <= 1'b1;
              state   <= ST_ACK;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2ct_regs.sv
`timescale 1ns/1ps
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RST_SLA = 10'h2A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ev_addr_hit,
  input  logic              ev_hit_rd,
  input  logic              ev_rx_byte,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ev_nak_used,
  input  logic              ev_bus_end,
  input  logic              ev_master_nak,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [STAT_W-1:0] stat_q,
  output logic              nak_req,
  output logic [ADDR_W-1:0] sla,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);
  logic [DATA_W-1:0] rx_data;
  logic rd_stat, rd_data;

  assign rd_stat = reg_rd && (reg_addr == REG_STAT);
  assign rd_data = reg_rd && (reg_addr == REG_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      rx_data <= '0;
      tx_data <= '0;
      nak_req <= 1'b0;
      sla     <= RST_SLA;
    end else begin
      // a setting event wins over a clearing read
      stat_q[STAT_SAM]  <= ev_addr_hit   | (stat_q[STAT_SAM]  & ~rd_stat);
      stat_q[STAT_RDRF] <= ev_rx_byte    | (stat_q[STAT_RDRF] & ~rd_data);
      stat_q[STAT_STOP] <= ev_bus_end    | (stat_q[STAT_STOP] & ~rd_stat);
      stat_q[STAT_MNAK] <= ev_master_nak | (stat_q[STAT_MNAK] & ~rd_stat);
      if (ev_addr_hit) stat_q[STAT_RD] <= ev_hit_rd;
      if (ev_rx_byte)  rx_data <= rx_byte;
      if (ev_nak_used) nak_req <= 1'b0;
      else if (reg_wr && reg_addr == REG_CTRL) nak_req <= reg_wdata[0];
      if (reg_wr && reg_addr == REG_DATA)   tx_data   <= reg_wdata;
      if (reg_wr && reg_addr == REG_SLA_LO) sla[7:0]  <= reg_wdata;
      if (reg_wr && reg_addr == REG_SLA_HI) sla[9:8]  <= reg_wdata[1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        REG_STAT:   reg_rdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
        REG_CTRL:   reg_rdata = {{(DATA_W-1){1'b0}}, nak_req};
        REG_DATA:   reg_rdata = rx_data;
        REG_SLA_LO: reg_rdata = sla[7:0];
        REG_SLA_HI: reg_rdata = {{(DATA_W-2){1'b0}}, sla[9:8]};
        default:    reg_rdata = '0;
      endcase
    end
  end

  assign irq = stat_q[STAT_SAM] | stat_q[STAT_RDRF] | stat_q[STAT_STOP] | stat_q[STAT_MNAK];
endmodule

// File: rtl/i2ct_target.sv
`timescale 1ns/1ps
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RST_SLA     = 10'h2A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic ev_addr_hit, ev_hit_rd, ev_rx_byte, ev_nak_used, ev_bus_end, ev_master_nak;
  logic eng_idle, nak_req;
  logic [DATA_W-1:0] rx_byte, tx_data;
  logic [ADDR_W-1:0] sla;
  logic [STAT_W-1:0] stat_q;

  i2ct_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2ct_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s), .sla(sla),
    .nak_req(nak_req), .tx_data(tx_data), .sda_drv(sda_oe),
    .ev_addr_hit(ev_addr_hit), .ev_hit_rd(ev_hit_rd), .ev_rx_byte(ev_rx_byte),
    .rx_byte(rx_byte), .ev_nak_used(ev_nak_used), .ev_bus_end(ev_bus_end),
    .ev_master_nak(ev_master_nak), .eng_idle(eng_idle)
  );

  i2ct_regs #(.RST_SLA(RST_SLA)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ev_addr_hit(ev_addr_hit), .ev_hit_rd(ev_hit_rd), .ev_rx_byte(ev_rx_byte),
    .rx_byte(rx_byte), .ev_nak_used(ev_nak_used), .ev_bus_end(ev_bus_end),
    .ev_master_nak(ev_master_nak), .reg_rdata(reg_rdata), .stat_q(stat_q),
    .nak_req(nak_req), .sla(sla), .tx_data(tx_data), .irq(irq)
  );
endmodule

// File: rtl/i2ct_chk.sv
`timescale 1ns/1ps
module i2ct_chk
  import i2ct_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              irq,
  input logic              eng_idle,
  input logic              ev_addr_hit,
  input logic              ev_hit_rd,
  input logic              ev_rx_byte,
  input logic              ev_bus_end,
  input logic              ev_master_nak,
  input logic [STAT_W-1:0] stat_q
);
  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);                                        // R12
  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_hit |=> stat_q[STAT_SAM]);                                   // R2
  AST_HIT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_hit |=> (stat_q[STAT_RD] == $past(ev_hit_rd)));              // R8
  AST_RX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_byte |=> stat_q[STAT_RDRF]);                                   // R5
  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_end |=> stat_q[STAT_STOP]);                                   // R11
  AST_MNAK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_master_nak |=> (stat_q[STAT_MNAK] && !sda_oe));                   // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sda_oe);                                               // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_addr_hit || ev_rx_byte || ev_bus_end || ev_master_nak)); // R7
endmodule

bind i2ct_target i2ct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .irq(irq),
  .eng_idle(eng_idle), .ev_addr_hit(ev_addr_hit), .ev_hit_rd(ev_hit_rd),
  .ev_rx_byte(ev_rx_byte), .ev_bus_end(ev_bus_end),
  .ev_master_nak(ev_master_nak), .stat_q(stat_q)
);

// File: tb/i2ct_target_tb.sv
`timescale 1ns/1ps
module i2ct_target_tb;
  import i2ct_pkg::*;

  localparam int H = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sda_oe, irq;
  wire  sda_bus = !(m_low || sda_oe);

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int exp_rx[$];
  int exp_tx[$];

  always #5 clk = ~clk;

  i2ct_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, int got, int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic spam(int n, int bitpos, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); reg_rd = 1'b1; reg_addr = REG_STAT;
      #1 if (reg_rdata[bitpos]) seen = 1'b1;
    end
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic bstart();
    if (!scl) begin cyc(4); m_low = 1'b0; cyc(H); scl = 1'b1; cyc(H); end
    m_low = 1'b1; cyc(H); scl = 1'b0;
  endtask

  task automatic bstop();
    cyc(4); m_low = 1'b1; cyc(H); scl = 1'b1; cyc(H); m_low = 1'b0; cyc(H);
  endtask

  task automatic wbit(logic b);
    cyc(4); m_low = !b; cyc(H); scl = 1'b1; cyc(H); scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    cyc(4); m_low = 1'b0; cyc(H); scl = 1'b1; cyc(H/2); b = sda_bus; cyc(H/2); scl = 1'b0;
  endtask

  task automatic wbyte(logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(a);
    acked = !a;
  endtask

  // driver side of the scoreboard: a data byte the target must store
  task automatic drv_rx(logic [7:0] b, output logic acked);
    exp_rx.push_back(b);
    wbyte(b, acked);
  endtask

  // monitor side: read the data port and compare with the oldest expectation
  task automatic mon_rx(string req);
    logic [7:0] d;
    int e;
    rd_reg(REG_DATA, d);
    e = (exp_rx.size() > 0) ? exp_rx.pop_front() : -1;
    chk(req, d, e);
  endtask

  task automatic load_tx(logic [7:0] b);
    exp_tx.push_back(b);
    wr_reg(REG_DATA, b);
  endtask

  task automatic mon_tx(logic give_ack, string req);
    logic [7:0] b;
    logic x;
    int e;
    for (int i = 7; i >= 0; i--) begin rbit(x); b[i] = x; end
    wbit(!give_ack);
    e = (exp_tx.size() > 0) ? exp_tx.pop_front() : -1;
    chk(req, b, e);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  // status bits: 0 hit, 1 read dir, 2 rx full, 3 end, 4 controller NAK
  localparam logic [7:0] HDR_W = {5'b11110, 2'b10, 1'b0};
  localparam logic [7:0] HDR_R = {5'b11110, 2'b10, 1'b1};
  localparam logic [7:0] LO    = 8'hA5;

  initial begin
    logic [7:0] s;
    logic a, seen;
    cyc(5); rst_n = 1'b1; cyc(5);

    rd_reg(REG_STAT, s);
    chk("R1 status", s, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sda_oe", sda_oe, 0);

    // write transfer with matching 10-bit address
    bstart();
    wbyte(HDR_W, a); chk("R2 header ack", a, 1);
    wbyte(LO, a);    chk("R2 low ack", a, 1);
    cyc(8);
    chk("R2 irq", irq, 1);
    rd_reg(REG_STAT, s); chk("R2 status", s, 8'h01);
    rd_reg(REG_STAT, s); chk("R4 hit cleared", s, 8'h00);
    chk("R4 irq low", irq, 0);

    drv_rx(8'h3C, a); chk("R5 data ack", a, 1);
    cyc(8);
    rd_reg(REG_STAT, s); chk("R5 rx flag", s, 8'h04);
    mon_rx("R5 data 1");
    rd_reg(REG_STAT, s); chk("R5 rx flag cleared", s, 8'h00);
    drv_rx(8'hC3, a); chk("R5 data ack 2", a, 1);
    mon_rx("R5 data 2");

    wr_reg(REG_CTRL, 8'h01);
    rd_reg(REG_CTRL, s); chk("R6 ctrl armed", s, 8'h01);
    drv_rx(8'h77, a); chk("R6 nak given", a, 0);
    cyc(8);
    rd_reg(REG_CTRL, s); chk("R6 ctrl self-clear", s, 8'h00);
    rd_reg(REG_STAT, s); chk("R6 rx flag", s, 8'h04);
    mon_rx("R6 stored byte");

    bstop();
    chk("R7 irq on stop", irq, 1);
    rd_reg(REG_STAT, s); chk("R7 stop flag", s, 8'h08);
    rd_reg(REG_STAT, s); chk("R4 stop cleared", s, 8'h00);

    // low byte mismatch, then ignored bytes
    bstart();
    wbyte(HDR_W, a);   chk("R3 header ack", a, 1);
    wbyte(8'h5A, a);   chk("R3 low mismatch", a, 0);
    wbyte(8'h11, a);   chk("R3 ignored byte", a, 0);
    bstop();
    rd_reg(REG_STAT, s); chk("R3 no flags", s, 8'h00);
    // header pair mismatch
    bstart();
    wbyte({5'b11110, 2'b01, 1'b0}, a); chk("R3 header mismatch", a, 0);
    wbyte(LO, a); chk("R3 ignored low", a, 0);
    bstop();
    rd_reg(REG_STAT, s); chk("R3 no flags 2", s, 8'h00);

    // read header without write match
    bstart();
    wbyte(HDR_R, a); chk("R10 read header rejected", a, 0);
    bstop();
    rd_reg(REG_STAT, s); chk("R10 no flags", s, 8'h00);

    // collision: flag set while status is read every cycle
    bstart();
    wbyte(HDR_W, a);
    fork
      wbyte(LO, a);
      spam(9 * (H * 2 + 4) + 20, STAT_SAM, seen);
    join
    chk("R11 hit seen during reads", seen, 1);
    drv_rx(8'h42, a);
    mon_rx("R5 data 3");
    fork
      bstop();
      spam(3 * H + 20, STAT_STOP, seen);
    join
    chk("R11 stop seen during reads", seen, 1);
    rd_reg(REG_STAT, s); chk("R11 flags drained", s, 8'h00);

    // write match, restart, read
    load_tx(8'h96);
    bstart();
    wbyte(HDR_W, a); wbyte(LO, a);
    rd_reg(REG_STAT, s);
    bstart();
    wbyte(HDR_R, a); chk("R8 read header ack", a, 1);
    cyc(8);
    rd_reg(REG_STAT, s); chk("R8 hit+dir, R7 restart", s, 8'h0B);
    load_tx(8'h5B);
    mon_tx(1'b1, "R8 byte 1");
    mon_tx(1'b0, "R8 byte 2");
    cyc(8);
    chk("R9 sda released", sda_oe, 0);
    rd_reg(REG_STAT, s); chk("R9 controller nak flag", s, 8'h12);
    bstop();
    rd_reg(REG_STAT, s); chk("R7 stop after read", s, 8'h0A);

    done = 1;
    summary();
  end
endmodule